// File: doc/BRIEF.md
# I2C Bus Controller Supervisor

This block holds the control word of an I2C bus controller and supervises how that controller takes part in bus traffic. It keeps the enable, leave-communication, wait-cancel, stop-interrupt-enable, wait-timing, ack-enable, start-request and stop-request bits. It tracks the status flags those bits affect, and it gates the controller's line drivers. The serial shift engine and the clock generator sit outside this block. They report bus events here as single-cycle pulses: start, stop, address hit, extension code, ack and transmit role. They also request line drive through two level inputs.

The main feature is the leave-communication command. It executes once, floats both lines and wipes the transfer flags, and then parks the block in a standby state. In standby the block ignores bus traffic until a stop condition arrives, or until an address hit or extension code follows a fresh start condition. The same command also suppresses the start condition that the detector reports by mistake when the block is enabled while SCL is high and SDA is low. All control and status pins are plain levels or single-cycle pulses. No data stream crosses this block, so it has no valid/ready handshake.

Top module: `i2c_bus_supervisor`

## Requirements
- R1: A synchronous active-high reset clears the control word and every status flag, leaves standby at 0, and holds both output enables low.
- R2: Control word bit positions: 7 enable, 6 leave-communication, 5 wait-cancel, 4 stop-interrupt-enable, 3 wait-timing, 2 ack-enable, 1 start-request, 0 stop-request. Bits 7 and 4..0 read back the last written value unless a clear event overrides them.
- R3: With enable at 1, a write of 1 to bit 6 or bit 5 reads back 1 in the next cycle and 0 one cycle later.
- R4: While enable reads 0, stat_flags, bus_busy, start_drop, scl_level, sda_level and standby are 0 after the next clock, and writes to bits 6 and 5 read back 0, cause no standby and give no wait_release pulse.
- R5: A leave-communication write (bit 6 = 1, enable already 1) sets standby, floats SCL and SDA, and clears the start-request and stop-request bits and all six stat_flags after the clock edge.
- R6: stat_flags bit order is [5] master, [4] extension code, [3] address hit, [2] transmit, [1] ack seen, [0] start seen. In standby, start, ack and transmit events set no flag, and an address hit or extension code sets no flag unless a start came after entry.
- R7: Standby ends on a stop pulse, or on an address hit or extension code after a start seen in standby. In the second case the matching flag is set.
- R8: A wait-cancel write with enable at 1 gives a wait_release pulse exactly one cycle long in the following cycle.
- R9: Leave-communication and wait-cancel written together both execute: wait_release pulses while both lines float.
- R10: A start pulse taken right after enabling sets the start-seen flag. A following leave-communication clears it, and a later address hit without a new start leaves standby at 1.
- R11: Outside standby with enable at 1, scl_oe and sda_oe follow the engine drive requests. In standby or when disabled they are 0.
- R12: A start pulse outside standby while start-request is 1 (and no stop in the same cycle) sets master and clears start-request. A stop pulse clears all stat_flags, bus_busy and stop-request.
- R13: bus_busy is set by start and cleared by stop. start_drop is set when leave-communication discards a pending start-request and cleared by a write with bit 1 = 1. scl_level and sda_level are the line levels one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 8 | Control word write data |
| reg_rdata | output | 8 | Control word readback |
| det_start | input | 1 | Start condition pulse |
| det_stop | input | 1 | Stop condition pulse |
| det_addr_hit | input | 1 | Own address matched pulse |
| det_ext_code | input | 1 | Extension code received pulse |
| det_ack | input | 1 | Acknowledge detected pulse |
| det_tx | input | 1 | Engine entered transmit role pulse |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| eng_scl_drv | input | 1 | Engine request to pull SCL low |
| eng_sda_drv | input | 1 | Engine request to pull SDA low |
| scl_oe | output | 1 | SCL pull-down enable |
| sda_oe | output | 1 | SDA pull-down enable |
| wait_release | output | 1 | One-cycle wait release to the engine |
| stat_flags | output | 6 | Transfer status flags |
| bus_busy | output | 1 | Bus between start and stop |
| start_drop | output | 1 | Pending start discarded by leave-communication |
| scl_level | output | 1 | Sampled SCL level |
| sda_level | output | 1 | Sampled SDA level |
| standby | output | 1 | Block parked, ignoring traffic |

## Verification
Random streams of event pulses and control writes run with enable mostly high. This separates the normal flag updates from the standby filtering, because releases land at arbitrary points relative to starts and address hits. Directed sequences take each standby exit path: a stop, an address hit without a prior start (which must not exit), and an address hit after a start (which must exit). This separates the start-gated exit from an exit on any address hit. Writes with enable low, and combined release plus wait-cancel writes, show whether the enable gating and the line-drive priority hold.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int unsigned REG_W = 8;
  localparam int unsigned B_EN   = 7;
  localparam int unsigned B_REL  = 6;
  localparam int unsigned B_WREL = 5;
  localparam int unsigned B_SPIE = 4;
  localparam int unsigned B_WTIM = 3;
  localparam int unsigned B_ACKE = 2;
  localparam int unsigned B_STT  = 1;
  localparam int unsigned B_SPT  = 0;

  typedef struct packed {
    logic master;
    logic ext;
    logic addr;
    logic tx;
    logic ack;
    logic start;
  } flags_t;

  localparam int unsigned FLAG_W = $bits(flags_t);
endpackage

// File: rtl/i2cs_ctrl_reg.sv
module i2cs_ctrl_reg
  import i2cs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             start_taken,
  input  logic             stop_seen,
  output logic [REG_W-1:0] ctrl_q,
  output logic             rel_exec,
  output logic             wrel_exec
);
  localparam logic [REG_W-1:0] PLAIN_MASK =
    REG_W'((1 << B_EN) | (1 << B_SPIE) | (1 << B_WTIM) | (1 << B_ACKE));

  assign rel_exec  = wr & wdata[B_REL]  & ctrl_q[B_EN];
  assign wrel_exec = wr & wdata[B_WREL] & ctrl_q[B_EN];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else begin
      ctrl_q[B_REL]  <= rel_exec;
      ctrl_q[B_WREL] <= wrel_exec;
      if (wr) begin
        for (int i = 0; i < REG_W; i++) begin
          if (PLAIN_MASK[i]) ctrl_q[i] <= wdata[i];
        end
        ctrl_q[B_STT] <= wdata[B_STT] & ~rel_exec;
        ctrl_q[B_SPT] <= wdata[B_SPT] & ~rel_exec;
      end else begin
        if (start_taken) ctrl_q[B_STT] <= 1'b0;
        if (stop_seen)   ctrl_q[B_SPT] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/i2cs_standby.sv
module i2cs_standby (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic rel_exec,
  input  logic det_start,
  input  logic det_stop,
  input  logic det_id,
  output logic standby,
  output logic armed
);
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      standby <= 1'b0;
      armed   <= 1'b0;
    end else if (rel_exec) begin
      standby <= 1'b1;
      armed   <= 1'b0;
    end else if (standby) begin
      if (det_stop || (armed && det_id)) begin
        standby <= 1'b0;
        armed   <= 1'b0;
      end else if (det_start) begin
        armed <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2cs_status.sv
module i2cs_status
  import i2cs_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   en,
  input  logic   rel_exec,
  input  logic   standby,
  input  logic   armed,
  input  logic   det_start,
  input  logic   det_stop,
  input  logic   det_addr,
  input  logic   det_ext,
  input  logic   det_ack,
  input  logic   det_tx,
  input  logic   stt_q,
  input  logic   stt_wr,
  input  logic   scl_in,
  input  logic   sda_in,
  output flags_t flags,
  output logic   busy,
  output logic   start_drop,
  output logic   scl_lvl,
  output logic   sda_lvl,
  output logic   start_taken
);
  logic live;
  logic id_ok;

  assign live        = ~standby;
  assign id_ok       = ~standby | armed;
  assign start_taken = en & live & det_start & ~det_stop & stt_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      flags      <= '0;
      busy       <= 1'b0;
      start_drop <= 1'b0;
      scl_lvl    <= 1'b0;
      sda_lvl    <= 1'b0;
    end else begin
      scl_lvl <= scl_in;
      sda_lvl <= sda_in;
      if (det_stop)       busy <= 1'b0;
      else if (det_start) busy <= 1'b1;
      if (rel_exec && stt_q) start_drop <= 1'b1;
      else if (stt_wr)       start_drop <= 1'b0;
      if (rel_exec || det_stop) begin
        flags <= '0;
      end else begin
        if (live && det_start)  flags.start  <= 1'b1;
        if (start_taken)        flags.master <= 1'b1;
        if (id_ok && det_addr)  flags.addr   <= 1'b1;
        if (id_ok && det_ext)   flags.ext    <= 1'b1;
        if (live && det_ack)    flags.ack    <= 1'b1;
        if (live && det_tx)     flags.tx     <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_bus_supervisor.sv
module i2c_bus_supervisor
  import i2cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              det_start,
  input  logic              det_stop,
  input  logic              det_addr_hit,
  input  logic              det_ext_code,
  input  logic              det_ack,
  input  logic              det_tx,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              eng_scl_drv,
  input  logic              eng_sda_drv,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              wait_release,
  output logic [FLAG_W-1:0] stat_flags,
  output logic              bus_busy,
  output logic              start_drop,
  output logic              scl_level,
  output logic              sda_level,
  output logic              standby
);
  logic [REG_W-1:0] ctrl_q;
  logic   rel_exec, wrel_exec, start_taken, armed, en, stt_wr;
  flags_t flags;

  assign en     = ctrl_q[B_EN];
  assign stt_wr = reg_wr & reg_wdata[B_STT] & ~rel_exec;

  i2cs_ctrl_reg u_ctrl (
    .clk(clk), .rst(rst), .wr(reg_wr), .wdata(reg_wdata),
    .start_taken(start_taken), .stop_seen(det_stop & en),
    .ctrl_q(ctrl_q), .rel_exec(rel_exec), .wrel_exec(wrel_exec)
  );

  i2cs_standby u_sby (
    .clk(clk), .rst(rst), .en(en), .rel_exec(rel_exec),
    .det_start(det_start), .det_stop(det_stop),
    .det_id(det_addr_hit | det_ext_code),
    .standby(standby), .armed(armed)
  );

  i2cs_status u_stat (
    .clk(clk), .rst(rst), .en(en), .rel_exec(rel_exec),
    .standby(standby), .armed(armed),
    .det_start(det_start), .det_stop(det_stop),
    .det_addr(det_addr_hit), .det_ext(det_ext_code),
    .det_ack(det_ack), .det_tx(det_tx),
    .stt_q(ctrl_q[B_STT]), .stt_wr(stt_wr),
    .scl_in(scl_in), .sda_in(sda_in),
    .flags(flags), .busy(bus_busy), .start_drop(start_drop),
    .scl_lvl(scl_level), .sda_lvl(sda_level), .start_taken(start_taken)
  );

  assign reg_rdata    = ctrl_q;
  assign stat_flags   = flags;
  assign wait_release = ctrl_q[B_WREL];
  assign scl_oe       = en & ~standby & eng_scl_drv;
  assign sda_oe       = en & ~standby & eng_sda_drv;
endmodule

// File: rtl/i2c_bus_supervisor_chk.sv
module i2c_bus_supervisor_chk (
  input logic       clk,
  input logic       rst,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       wait_release,
  input logic [5:0] stat_flags,
  input logic       bus_busy,
  input logic       standby
);
  // R3
  rel_self_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata[6] && !(reg_wr && reg_wdata[6])) |=> !reg_rdata[6]);

  // R4
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_rdata[7] |=> (stat_flags == 6'd0 && !bus_busy && !standby));

  // R5
  release_float_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_wdata[6] && reg_rdata[7]) |=>
      (standby && !scl_oe && !sda_oe && stat_flags == 6'd0 && reg_rdata[1:0] == 2'b00));

  // R8
  wait_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (wait_release && !(reg_wr && reg_wdata[5] && reg_rdata[7])) |=> !wait_release);

  // R11
  float_in_standby_chk: assert property (@(posedge clk) disable iff (rst)
    standby |-> (!scl_oe && !sda_oe));

  // R6
  standby_no_start_chk: assert property (@(posedge clk) disable iff (rst)
    standby |=> !stat_flags[0]);
endmodule

bind i2c_bus_supervisor i2c_bus_supervisor_chk u_chk (.*);

// File: tb/test_i2c_bus_supervisor.sv
`timescale 1ns/1ps
module test_i2c_bus_supervisor;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic det_start = 0, det_stop = 0, det_addr_hit = 0, det_ext_code = 0, det_ack = 0, det_tx = 0;
  logic scl_in = 1, sda_in = 1, eng_scl_drv = 0, eng_sda_drv = 0;
  logic [7:0] reg_rdata;
  logic scl_oe, sda_oe, wait_release, bus_busy, start_drop, scl_level, sda_level, standby;
  logic [5:0] stat_flags;

  int checks = 0;
  int fails = 0;

  // Spec model state
  logic [7:0] m_ctrl;
  logic [5:0] m_flags;
  logic m_busy, m_drop, m_scl, m_sda, m_sb, m_armed;

  always #10 clk = ~clk;

  i2c_bus_supervisor i_i2c_bus_supervisor (.*);

  always @(posedge clk) begin
    logic en, rel, wrl, taken, live, idok, sw;
    logic [7:0] nc;
    logic [5:0] nf;
    if (rst) begin
      m_ctrl = 0; m_flags = 0; m_busy = 0; m_drop = 0; m_scl = 0; m_sda = 0; m_sb = 0; m_armed = 0;
    end else begin
      en = m_ctrl[7];
      rel = reg_wr & reg_wdata[6] & en;
      wrl = reg_wr & reg_wdata[5] & en;
      live = ~m_sb;
      idok = ~m_sb | m_armed;
      taken = en & live & det_start & ~det_stop & m_ctrl[1];
      sw = reg_wr & reg_wdata[1] & ~rel;
      nc = m_ctrl;
      nc[6] = rel; nc[5] = wrl;
      if (reg_wr) begin
        nc[7] = reg_wdata[7]; nc[4:2] = reg_wdata[4:2];
        nc[1] = reg_wdata[1] & ~rel; nc[0] = reg_wdata[0] & ~rel;
      end else begin
        if (taken) nc[1] = 0;
        if (det_stop && en) nc[0] = 0;
      end
      if (!en) begin
        m_flags = 0; m_busy = 0; m_drop = 0; m_scl = 0; m_sda = 0; m_sb = 0; m_armed = 0;
      end else begin
        m_scl = scl_in; m_sda = sda_in;
        if (det_stop) m_busy = 0; else if (det_start) m_busy = 1;
        if (rel && m_ctrl[1]) m_drop = 1; else if (sw) m_drop = 0;
        nf = m_flags;
        if (rel || det_stop) nf = 0;
        else begin
          if (live && det_start) nf[0] = 1;
          if (taken) nf[5] = 1;
          if (idok && det_addr_hit) nf[3] = 1;
          if (idok && det_ext_code) nf[4] = 1;
          if (live && det_ack) nf[1] = 1;
          if (live && det_tx) nf[2] = 1;
        end
        m_flags = nf;
        if (rel) begin m_sb = 1; m_armed = 0; end
        else if (m_sb) begin
          if (det_stop || (m_armed && (det_addr_hit || det_ext_code))) begin m_sb = 0; m_armed = 0; end
          else if (det_start) m_armed = 1;
        end
      end
      m_ctrl = nc;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic en;
    en = m_ctrl[7];
    check("R2 readback", reg_rdata, m_ctrl);
    check("R6 flags", stat_flags, m_flags);
    check("R7 standby", standby, m_sb);
    check("R11 scl_oe", scl_oe, en & ~m_sb & eng_scl_drv);
    check("R11 sda_oe", sda_oe, en & ~m_sb & eng_sda_drv);
    check("R8 wait_release", wait_release, m_ctrl[5]);
    check("R13 busy/drop/levels", {bus_busy, start_drop, scl_level, sda_level}, {m_busy, m_drop, m_scl, m_sda});
  endtask

  task automatic step();
    #1 compare_all();
    @(negedge clk);
    reg_wr = 0; det_start = 0; det_stop = 0; det_addr_hit = 0;
    det_ext_code = 0; det_ack = 0; det_tx = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    reg_wr = 1; reg_wdata = d; step();
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk); @(negedge clk);
    rst = 0;
    eng_scl_drv = 1; eng_sda_drv = 1;
    #1;
    // R1 reset state
    check("R1 rdata", reg_rdata, 8'h00);
    check("R1 flags/standby/oe", {stat_flags, standby, scl_oe, sda_oe}, 9'd0);
    @(negedge clk);

    // R4 disabled: release and wait-cancel ignored
    wr(8'h60);
    check("R4 rel/wrel readback", reg_rdata[6:5], 2'b00);
    check("R4 no standby/pulse", {standby, wait_release}, 2'b00);

    // R10 enable with SCL high, SDA low -> spurious start
    scl_in = 1; sda_in = 0;
    wr(8'h80);
    det_start = 1; step();
    check("R10 spurious start seen", stat_flags[0], 1'b1);
    wr(8'hC0);
    check("R10 start cleared by release", stat_flags, 6'd0);
    check("R5 standby and float", {standby, scl_oe, sda_oe}, 3'b100);
    check("R3 release reads 1", reg_rdata[6], 1'b1);
    step();
    check("R3 release reads 0", reg_rdata[6], 1'b0);
    sda_in = 1;
    det_addr_hit = 1; step();
    check("R10 addr without start keeps standby", {standby, stat_flags[3]}, 2'b10);
    det_ack = 1; det_start = 1; step();
    check("R6 ack/start ignored in standby", stat_flags, 6'd0);
    det_addr_hit = 1; step();
    check("R7 exit on addr after start", {standby, stat_flags[3]}, 2'b01);

    // R12 start request, then stop
    wr(8'h83);
    det_start = 1; step();
    check("R12 master set", stat_flags[5], 1'b1);
    check("R12 start-request cleared", reg_rdata[1:0], 2'b01);
    det_stop = 1; step();
    check("R12 stop clears", {stat_flags, bus_busy, reg_rdata[0]}, 8'd0);

    // R13 discarded start request
    wr(8'h82);
    wr(8'hC0);
    check("R13 start_drop set", start_drop, 1'b1);
    det_stop = 1; step();
    check("R7 exit on stop", standby, 1'b0);
    wr(8'h82);
    check("R13 start_drop cleared", start_drop, 1'b0);

    // R9 release and wait-cancel together
    wr(8'hE0);
    check("R9 both execute", {wait_release, standby, scl_oe, sda_oe}, 4'b1100);
    step();
    check("R8 pulse one cycle", wait_release, 1'b0);
    det_stop = 1; step();

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      reg_wr = ($urandom % 5) == 0;
      reg_wdata = 8'($urandom);
      reg_wdata[7] = ($urandom % 10) != 0;
      reg_wdata[6] = ($urandom % 6) == 0;
      det_start = ($urandom % 8) == 0;
      det_stop = ($urandom % 14) == 0;
      det_addr_hit = ($urandom % 7) == 0;
      det_ext_code = ($urandom % 12) == 0;
      det_ack = ($urandom % 6) == 0;
      det_tx = ($urandom % 9) == 0;
      scl_in = 1'($urandom); sda_in = 1'($urandom);
      eng_scl_drv = 1'($urandom); eng_sda_drv = 1'($urandom);
      step();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule